// File: doc/BRIEF.md
# Bearer Channel Receive FIFO with Block Threshold Events

This block is the receive side of a 64/56 kbps bearer channel. A serial deframer hands it one octet at a time on a byte-valid strobe. The deframer marks the last octet of each frame and supplies the CRC verdict alongside it. The block stores the octets in a circular FIFO. Each time a block of the selected size has arrived, it raises a block-ready event. When a frame ends, it raises a frame-end event. When the FIFO is written while full, it raises an overflow event. It also counts the octets of the running frame.

A host reads the block over a small register bus: a data port that pops the FIFO, a read-to-clear event status register, a frame length split over two registers, and a frame status register holding the latched CRC verdict. The expected host loop is to drain one block per block-ready event. On frame end, the host fetches the length and the remaining octets.

Top module: `bch_rx_fifo`

## Requirements
- R1: After reset, the event status, both length registers and the frame status read 0x00, and a data read returns 0x00 because the FIFO is empty.
- R2: Octets read from the data port (address 0) come out in arrival order. Each data read removes one octet. A data read of an empty FIFO returns 0x00.
- R3: The block size is set by thr_sel: code 2'b10 selects 48 octets and code 2'b00 selects 32 octets. The codes 2'b01 and 2'b11 also fall back to 32 octets. A block-ready event (status bit 4) is raised each time a block of that size has been stored without the frame ending.
- R4: The octet flagged with in_last raises a frame-end event (status bit 3). The octets left to read then equal the frame length modulo the block size, or one full block when that modulo is zero.
- R5: When the last octet of a frame completes a block, only the frame-end event is raised for that block and no block-ready event is raised.
- R6: At frame end, the frame length in octets is latched: the low 8 bits are at address 2 and the high 4 bits are at address 3, bits 3:0. The running count then restarts at zero for the next frame.
- R7: The running octet count, and so the latched length, saturates at 4095.
- R8: A write into a full FIFO with no simultaneous data read raises an overflow event (status bit 2). It drops the oldest stored octet and keeps the new one, so the FIFO stays full.
- R9: The event status register is at address 1. A read returns its bits and then clears them. Bits 7:5 and 1:0 always read 0.
- R10: An event raised in the same cycle as a status read is returned as set on the next status read.
- R11: At frame end, in_crc_err is latched into bit 0 of the frame status register at address 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_sel | input | 2 | Block size select |
| in_vld | input | 1 | Received octet valid |
| in_data | input | 8 | Received octet |
| in_last | input | 1 | Marks the last octet of a frame, qualified by in_vld |
| in_crc_err | input | 1 | CRC verdict of the frame, sampled with the last octet |
| hb_rd | input | 1 | Host read strobe |
| hb_addr | input | 3 | Host register address |
| hb_rdata | output | 8 | Host read data, registered, valid from the edge that takes hb_rd |

## Verification
An octet accepted at a clock edge updates the FIFO level, the block counter and the event status at that same edge. The status therefore reflects it for a read issued in the next cycle. A host read is answered at the edge that takes the strobe, so hb_rdata is due one cycle after hb_rd is raised. The bench drives inputs on falling edges and samples hb_rdata on the falling edge after the strobe. It issues reads only after the octet that must be visible has been taken, except in the deliberate same-cycle read-and-event case. That case checks that the current read returns the old value and the next read shows the new event.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int DATA_W  = 8;
    localparam int CNT_W   = 12;
    localparam int BLK_W   = 6;
    localparam int THR_MAX = 48;

    localparam int STAT_READY_BIT = 4;
    localparam int STAT_END_BIT   = 3;
    localparam int STAT_OVF_BIT   = 2;

    typedef enum logic [2:0] {
        ADDR_DATA   = 3'd0,
        ADDR_STAT   = 3'd1,
        ADDR_LEN_LO = 3'd2,
        ADDR_LEN_HI = 3'd3,
        ADDR_FSTAT  = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic ready;
        logic fend;
        logic ovf;
    } rx_evt_t;

    // Block size chosen by the 2-bit select; undefined codes use the small size.
    function automatic logic [BLK_W-1:0] thr_bytes(input logic [1:0] sel);
        return (sel == 2'b10) ? BLK_W'(48) : BLK_W'(32);
    endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DEPTH = 64,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         drop
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW:0]   level;
    logic          empty;
    logic          pop_ok;
    logic          adv_rd;

    assign empty  = (level == '0);
    assign full   = (level == (AW+1)'(DEPTH));
    assign pop_ok = pop && !empty;
    assign drop   = push && full && !pop_ok;
    assign adv_rd = pop_ok || drop;
    assign dout   = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (adv_rd) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            case ({push, adv_rd})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        level <= (AW+1)'(DEPTH)) else $error("level above depth"); // R8

    AST_DROP_STAYS_FULL: assert property (@(posedge clk) disable iff (rst)
        drop |=> full) else $error("fifo left full state on overwrite"); // R8

endmodule

// File: rtl/rxf_framer.sv
module rxf_framer
    import rxf_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          last,
    input  logic          crc_in,
    input  logic [1:0]    thr_sel,
    output logic          ev_ready,
    output logic          ev_fend,
    output logic [CW-1:0] frame_len,
    output logic          crc_flag
);
    localparam logic [CW-1:0] RUN_MAX = '1;

    logic [BLK_W-1:0] thr;
    logic [BLK_W-1:0] blk_cnt;
    logic [BLK_W-1:0] blk_next;
    logic             blk_full;
    logic [CW-1:0]    run_cnt;
    logic [CW-1:0]    run_next;

    assign thr      = thr_bytes(thr_sel);
    assign blk_next = blk_cnt + 1'b1;
    assign blk_full = (blk_next >= thr);
    assign run_next = (run_cnt == RUN_MAX) ? RUN_MAX : run_cnt + 1'b1;

    // Frame end wins over block completion on the same octet.
    assign ev_fend  = push && last;
    assign ev_ready = push && !last && blk_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_cnt   <= '0;
            run_cnt   <= '0;
            frame_len <= '0;
            crc_flag  <= 1'b0;
        end else if (push) begin
            if (last || blk_full) begin
                blk_cnt <= '0;
            end else begin
                blk_cnt <= blk_next;
            end
            if (last) begin
                run_cnt   <= '0;
                frame_len <= run_next;
                crc_flag  <= crc_in;
            end else begin
                run_cnt <= run_next;
            end
        end
    end

    AST_BLK_BELOW_MAX: assert property (@(posedge clk) disable iff (rst)
        blk_cnt < BLK_W'(THR_MAX)) else $error("block count out of range"); // R3

    AST_RUN_RESTART: assert property (@(posedge clk) disable iff (rst)
        ev_fend |=> (run_cnt == '0)) else $error("running count not restarted"); // R6

    AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
        ev_fend |=> (frame_len != '0)) else $error("latched length zero"); // R6

    AST_RUN_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (push && !last && run_cnt == RUN_MAX) |=> (run_cnt == RUN_MAX))
        else $error("running count wrapped"); // R7

endmodule

// File: rtl/rxf_host.sv
module rxf_host
    import rxf_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic [2:0]        addr,
    input  rx_evt_t           evt,
    input  logic [DATA_W-1:0] fifo_dout,
    input  logic [CW-1:0]     frame_len,
    input  logic              crc_flag,
    output logic              pop,
    output logic [DATA_W-1:0] rdata
);
    logic [7:0]  status;
    logic [7:0]  evt_bits;
    logic [7:0]  status_nxt;
    logic [15:0] len16;
    logic        rd_stat;
    logic [7:0]  rd_mux;

    assign rd_stat = rd && (addr == ADDR_STAT);
    assign pop     = rd && (addr == ADDR_DATA);
    assign len16   = 16'(frame_len);

    always_comb begin
        evt_bits = '0;
        evt_bits[STAT_READY_BIT] = evt.ready;
        evt_bits[STAT_END_BIT]   = evt.fend;
        evt_bits[STAT_OVF_BIT]   = evt.ovf;
    end

    // Clear on read, but a same-cycle event lands after the clear.
    assign status_nxt = (rd_stat ? 8'h00 : status) | evt_bits;

    always_comb begin
        case (addr)
            ADDR_DATA:   rd_mux = fifo_dout;
            ADDR_STAT:   rd_mux = status;
            ADDR_LEN_LO: rd_mux = len16[7:0];
            ADDR_LEN_HI: rd_mux = len16[15:8];
            ADDR_FSTAT:  rd_mux = {7'b0, crc_flag};
            default:     rd_mux = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= 8'h00;
            rdata  <= '0;
        end else begin
            status <= status_nxt;
            if (rd) begin
                rdata <= rd_mux;
            end
        end
    end

    AST_STAT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && evt_bits == 8'h00) |=> (status == 8'h00))
        else $error("status not cleared by read"); // R9

    AST_END_KEPT: assert property (@(posedge clk) disable iff (rst)
        evt.fend |=> status[STAT_END_BIT]) else $error("frame-end event lost"); // R10

    AST_OVF_KEPT: assert property (@(posedge clk) disable iff (rst)
        evt.ovf |=> status[STAT_OVF_BIT]) else $error("overflow event lost"); // R8

endmodule

// File: rtl/bch_rx_fifo.sv
module bch_rx_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] thr_sel,
    input  logic       in_vld,
    input  logic [7:0] in_data,
    input  logic       in_last,
    input  logic       in_crc_err,
    input  logic       hb_rd,
    input  logic [2:0] hb_addr,
    output logic [7:0] hb_rdata
);
    logic              pop;
    logic              full;
    logic              drop;
    logic [DATA_W-1:0] fifo_dout;
    logic              ev_ready;
    logic              ev_fend;
    logic [CNT_W-1:0]  frame_len;
    logic              crc_flag;
    rx_evt_t           evt;

    assign evt.ready = ev_ready;
    assign evt.fend  = ev_fend;
    assign evt.ovf   = drop;

    rxf_store #(.DEPTH(DEPTH), .W(DATA_W)) u_store (
        .clk  (clk),
        .rst  (rst),
        .push (in_vld),
        .din  (in_data),
        .pop  (pop),
        .dout (fifo_dout),
        .full (full),
        .drop (drop)
    );

    rxf_framer #(.CW(CNT_W)) u_framer (
        .clk       (clk),
        .rst       (rst),
        .push      (in_vld),
        .last      (in_last),
        .crc_in    (in_crc_err),
        .thr_sel   (thr_sel),
        .ev_ready  (ev_ready),
        .ev_fend   (ev_fend),
        .frame_len (frame_len),
        .crc_flag  (crc_flag)
    );

    rxf_host #(.CW(CNT_W)) u_host (
        .clk       (clk),
        .rst       (rst),
        .rd        (hb_rd),
        .addr      (hb_addr),
        .evt       (evt),
        .fifo_dout (fifo_dout),
        .frame_len (frame_len),
        .crc_flag  (crc_flag),
        .pop       (pop),
        .rdata     (hb_rdata)
    );

    AST_READY_END_APART: assert property (@(posedge clk) disable iff (rst)
        !(evt.ready && evt.fend)) else $error("ready raised with frame end"); // R5

endmodule

// File: tb/bch_rx_fifo_bench.sv
module bch_rx_fifo_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] thr_sel;
    logic       in_vld;
    logic [7:0] in_data;
    logic       in_last;
    logic       in_crc_err;
    logic       hb_rd;
    logic [2:0] hb_addr;
    logic [7:0] hb_rdata;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    bch_rx_fifo u_bch_rx_fifo (
        .clk(clk), .rst(rst), .thr_sel(thr_sel), .in_vld(in_vld),
        .in_data(in_data), .in_last(in_last), .in_crc_err(in_crc_err),
        .hb_rd(hb_rd), .hb_addr(hb_addr), .hb_rdata(hb_rdata)
    );

    // {sel[31:30], crc[29], pad[28], len[27:16], ready events[15:8], leftover[7:0]}
    localparam logic [31:0] VECS [6] = '{
        {2'b00, 1'b0, 1'b0, 12'd40,  8'd1, 8'd8},
        {2'b10, 1'b1, 1'b0, 12'd100, 8'd2, 8'd4},
        {2'b00, 1'b0, 1'b0, 12'd64,  8'd1, 8'd32},
        {2'b01, 1'b1, 1'b0, 12'd33,  8'd1, 8'd1},
        {2'b11, 1'b0, 1'b0, 12'd5,   8'd0, 8'd5},
        {2'b10, 1'b1, 1'b0, 12'd48,  8'd0, 8'd48}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic last, input logic crc);
        @(negedge clk);
        in_vld = 1'b1; in_data = d; in_last = last; in_crc_err = crc;
        @(negedge clk);
        in_vld = 1'b0; in_last = 1'b0; in_crc_err = 1'b0;
    endtask

    task automatic hread(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        hb_rd = 1'b1; hb_addr = a;
        @(negedge clk);
        hb_rd = 1'b0;
        d = hb_rdata;
    endtask

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'(((k * 7 + seed) % 255) + 1);
    endfunction

    task automatic run_frame(input logic [1:0] sel, input int len, input logic crc,
                             input int exp_len, input int exp_rdy, input int exp_left,
                             input int seed);
        int thr = (sel == 2'b10) ? 48 : 32;
        int blk = 0;
        int rd_k = 0;
        int nrdy = 0;
        logic [7:0] d;
        thr_sel = sel;
        for (int i = 0; i < len; i++) begin
            push(pat(seed, i), (i == len - 1), crc);
            if (i != len - 1) begin
                blk++;
                if (blk == thr) begin
                    blk = 0;
                    nrdy++;
                    hread(3'd1, d);
                    check("R3 block-ready status", d, 8'h10);
                    for (int j = 0; j < thr; j++) begin
                        hread(3'd0, d);
                        check("R2 block data order", d, pat(seed, rd_k));
                        rd_k++;
                    end
                end
            end
        end
        check("R3 ready event count", nrdy, exp_rdy);
        hread(3'd1, d);
        check("R5 frame end status, no ready", d, 8'h08);
        hread(3'd2, d);
        check("R6 length low", d, exp_len & 8'hFF);
        hread(3'd3, d);
        check("R6 length high", d, exp_len >> 8);
        hread(3'd4, d);
        check("R11 crc flag", d, {7'b0, crc});
        check("R4 leftover octets", len - rd_k, exp_left);
        for (int j = rd_k; j < len; j++) begin
            hread(3'd0, d);
            check("R4 leftover data", d, pat(seed, j));
        end
        hread(3'd0, d);
        check("R2 empty read", d, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        rst = 1'b1; thr_sel = 2'b00; in_vld = 1'b0; in_data = '0; in_last = 1'b0;
        in_crc_err = 1'b0; hb_rd = 1'b0; hb_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        hread(3'd1, d); check("R1 status after reset", d, 8'h00);
        hread(3'd2, d); check("R1 length low after reset", d, 8'h00);
        hread(3'd3, d); check("R1 length high after reset", d, 8'h00);
        hread(3'd4, d); check("R1 crc after reset", d, 8'h00);
        hread(3'd0, d); check("R1 data after reset", d, 8'h00);

        for (int v = 0; v < 6; v++) begin
            run_frame(VECS[v][31:30], int'(VECS[v][27:16]), VECS[v][29],
                      int'(VECS[v][27:16]), int'(VECS[v][15:8]), int'(VECS[v][7:0]), v * 13);
        end

        // R7 saturation: 4100 octets, length pinned at 4095
        run_frame(2'b00, 4100, 1'b0, 4095, 128, 4, 99);

        // R8 overflow: 70 octets into 64 places, no host reads
        thr_sel = 2'b00;
        for (int i = 0; i < 70; i++) push(8'(i + 1), 1'b0, 1'b0);
        hread(3'd1, d); check("R8 ready and overflow status", d, 8'h14);
        for (int j = 0; j < 64; j++) begin
            hread(3'd0, d); check("R8 oldest dropped", d, j + 7);
        end
        hread(3'd0, d); check("R8 fifo drained", d, 8'h00);
        push(8'hAA, 1'b1, 1'b0);
        hread(3'd1, d); check("R4 end after overflow", d, 8'h08);
        hread(3'd2, d); check("R6 length counts dropped octets", d, 71);
        hread(3'd0, d); check("R2 last octet kept", d, 8'hAA);

        // R9 second status read is clear
        hread(3'd1, d); check("R9 status cleared", d, 8'h00);

        // R10 frame end in the same cycle as a status read
        @(negedge clk);
        in_vld = 1'b1; in_data = 8'h55; in_last = 1'b1; in_crc_err = 1'b1;
        hb_rd = 1'b1; hb_addr = 3'd1;
        @(negedge clk);
        in_vld = 1'b0; in_last = 1'b0; in_crc_err = 1'b0; hb_rd = 1'b0;
        check("R10 read returns old status", hb_rdata, 8'h00);
        hread(3'd1, d); check("R10 event kept after read", d, 8'h08);
        hread(3'd2, d); check("R6 restart after frame", d, 1);
        hread(3'd4, d); check("R11 crc error latched", d, 8'h01);
        hread(3'd0, d); check("R2 single octet", d, 8'h55);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule